// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block is a one-stage registered buffer for the address and command lines that fan out to a memory rank. On each rising clock edge it registers a 28-bit data bus and six control lines. The control lines are two active-low chip selects, two on-die-termination bits and two clock-enable bits. It drives the registered copies onward. A gating enable sets when the data path loads. With the gate off, the data loads on every edge. With the gate on, the data loads only on edges where at least one chip select is asserted. On all other edges the data outputs keep their value. The control lines load on every edge.

A configuration select picks one of two subsets of the data bits. Only the bits in that subset pass through. The parity bit for a captured word arrives one clock after the word. It is checked against the word as an even-parity check. The result appears on an active-low error output one clock after the data output changed.

The asynchronous active-low reset clears every register as soon as it is asserted. Its release passes through a two-stage synchronizer, so the block leaves reset on a clock edge.

Top module: `csgate_cmd_reg`

## Requirements
- R1: With `gate_en` low, every rising edge loads `d_in`, masked by the configuration, into `q_data`, whatever the chip selects are.
- R2: With `gate_en` high, an edge on which at least one bit of `cs_n_in` is 0 loads the masked `d_in` into `q_data`.
- R3: With `gate_en` high and `cs_n_in` equal to 2'b11, `q_data` keeps its previous value across the edge.
- R4: `cs_n_q`, `odt_q` and `cke_q` take the values of `cs_n_in`, `odt_in` and `cke_in` on every edge, whatever the gating does.
- R5: The `par_in` value present on the edge after a capture is paired with the captured word. If the XOR of the 28 `q_data` bits and `par_in` is 1, `err_n` goes to 0. Otherwise `err_n` is 1. The inactive bits are 0, so they do not affect the result.
- R6: `err_n` changes one edge after the `q_data` update it refers to. A low pulse lasts one cycle unless the next check also fails.
- R7: Bit n of the bus is `d_in[n-1]`. With `cfg_sel` = 0, bits 6, 8 and 13 to 16 are inactive. With `cfg_sel` = 1, bits 13 to 16, 21 and 23 are inactive. Inactive bits are driven 0 on `q_data`.
- R8: If the previous edge did not capture data, because the gating held it, `err_n` is 1 after the edge, whatever `par_in` is.
- R9: Asserting `rst_n` low clears `q_data`, `cs_n_q`, `odt_q` and `cke_q` to 0 and sets `err_n` to 1, with no clock edge needed.
- R10: After `rst_n` rises, the first two rising edges leave every register in reset. The third edge is the first that loads data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 1 | Selects which data bits are active |
| gate_en | input | 1 | When high, data loads only on edges with a chip select asserted |
| d_in | input | 28 | Address/command data bus |
| par_in | input | 1 | Parity bit for the word captured one edge earlier |
| cs_n_in | input | 2 | Active-low chip selects |
| odt_in | input | 2 | Termination control bits |
| cke_in | input | 2 | Clock-enable bits |
| q_data | output | 28 | Registered, masked data bus |
| cs_n_q | output | 2 | Registered chip selects |
| odt_q | output | 2 | Registered termination bits |
| cke_q | output | 2 | Registered clock-enable bits |
| err_n | output | 1 | Active-low parity error flag |

## Verification
The clocked properties assume that the inputs settle between edges and hold through each rising edge. They also assume that `par_in` belongs to the word captured on the previous edge. Apart from that, the properties are checked only while the synchronized reset is released. The bench changes every input at the falling edge only. It computes each parity bit from the word it drove one step earlier. It then inverts that bit on purpose only where an error pulse is expected. Reset is asserted between edges, so its asynchronous effect can be seen before any edge arrives.

// File: rtl/csgcr_pkg.sv
package csgcr_pkg;

  localparam int unsigned DATA_W = 28;

  typedef enum logic {
    CFG_A = 1'b0,
    CFG_B = 1'b1
  } cfg_e;

  // Active-bit mask; bit index i corresponds to bus bit number i+1.
  function automatic logic [DATA_W-1:0] active_mask(input logic sel);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int n = 1; n <= int'(DATA_W); n++) begin
      if (sel == CFG_A) begin
        m[n-1] = (n <= 5) || (n == 7) || (n >= 9 && n <= 12) || (n >= 17);
      end else begin
        m[n-1] = (n <= 12) || (n >= 17 && n <= 20) || (n == 22) || (n >= 24);
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/csgcr_rst_sync.sv
module csgcr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/csgcr_ctrl_reg.sv
module csgcr_ctrl_reg #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

  // R4: control lines follow their inputs on every edge
  assert_ctrl_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q == $past(d)));

endmodule

// File: rtl/csgcr_data_reg.sv
module csgcr_data_reg
  import csgcr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate_en,
  input  logic [1:0]   cs_n,
  input  logic         cfg_sel,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_data,
  output logic         cap_q
);

  logic         capture;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         cap_nxt;

  always_comb begin
    capture = !gate_en || !(&cs_n);
    cap_nxt = capture;
    q_nxt   = q_r;
    if (capture) begin
      q_nxt = d_in & active_mask(cfg_sel);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= '0;
      cap_q <= 1'b0;
    end else begin
      q_r   <= q_nxt;
      cap_q <= cap_nxt;
    end
  end

  assign q_data = q_r;

  assert_load_ungated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> (q_data == ($past(d_in) & active_mask($past(cfg_sel)))));

  assert_load_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && (cs_n != 2'b11)) |=> (q_data == ($past(d_in) & active_mask($past(cfg_sel)))));

  assert_hold_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && (cs_n == 2'b11)) |=> $stable(q_data));

  assert_inactive_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en == 1'b0) |=> ((q_data & ~active_mask($past(cfg_sel))) == '0));

endmodule

// File: rtl/csgcr_parity_chk.sv
module csgcr_parity_chk #(
  parameter int unsigned W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] q_data,
  input  logic         cap_q,
  input  logic         par_in,
  output logic         err_n
);

  logic mismatch;
  logic err_nxt;
  logic err_r;

  always_comb begin
    mismatch = (^q_data) ^ par_in;
    err_nxt  = 1'b1;
    if (cap_q) begin
      err_nxt = !mismatch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_r <= 1'b1;
    end else begin
      err_r <= err_nxt;
    end
  end

  assign err_n = err_r;

  assert_no_check_when_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_q |=> err_n);

  assert_flag_on_mismatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_q && ((^q_data) != par_in)) |=> !err_n);

  assert_err_after_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |-> $past(cap_q));

endmodule

// File: rtl/csgate_cmd_reg.sv
module csgate_cmd_reg
  import csgcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel,
  input  logic              gate_en,
  input  logic [DATA_W-1:0] d_in,
  input  logic              par_in,
  input  logic [1:0]        cs_n_in,
  input  logic [1:0]        odt_in,
  input  logic [1:0]        cke_in,
  output logic [DATA_W-1:0] q_data,
  output logic [1:0]        cs_n_q,
  output logic [1:0]        odt_q,
  output logic [1:0]        cke_q,
  output logic              err_n
);

  localparam int unsigned CTRL_W = 6;

  logic              rst_int_n;
  logic              cap_q;
  logic [CTRL_W-1:0] ctrl_q;

  csgcr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  csgcr_data_reg #(.W(DATA_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .gate_en (gate_en),
    .cs_n    (cs_n_in),
    .cfg_sel (cfg_sel),
    .d_in    (d_in),
    .q_data  (q_data),
    .cap_q   (cap_q)
  );

  csgcr_ctrl_reg #(.W(CTRL_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({cke_in, odt_in, cs_n_in}),
    .q     (ctrl_q)
  );

  assign cs_n_q = ctrl_q[1:0];
  assign odt_q  = ctrl_q[3:2];
  assign cke_q  = ctrl_q[5:4];

  csgcr_parity_chk #(.W(DATA_W)) u_par (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .q_data (q_data),
    .cap_q  (cap_q),
    .par_in (par_in),
    .err_n  (err_n)
  );

endmodule

// File: tb/csgate_cmd_reg_test.sv
`timescale 1ns/1ps
module csgate_cmd_reg_test;

  logic        clk;
  logic        rst_n;
  logic        cfg_sel;
  logic        gate_en;
  logic [27:0] d_in;
  logic        par_in;
  logic [1:0]  cs_n_in;
  logic [1:0]  odt_in;
  logic [1:0]  cke_in;
  logic [27:0] q_data;
  logic [1:0]  cs_n_q;
  logic [1:0]  odt_q;
  logic [1:0]  cke_q;
  logic        err_n;

  int n_chk;
  int n_fail;

  logic [27:0] m_q;
  logic        m_cap;
  logic        m_err;
  logic [5:0]  m_ctrl;

  csgate_cmd_reg uut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .gate_en(gate_en),
    .d_in(d_in), .par_in(par_in), .cs_n_in(cs_n_in), .odt_in(odt_in),
    .cke_in(cke_in), .q_data(q_data), .cs_n_q(cs_n_q), .odt_q(odt_q),
    .cke_q(cke_q), .err_n(err_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Inactive bit numbers per R7, cleared from an all-ones word.
  function automatic logic [27:0] bench_mask(input logic sel);
    logic [27:0] m;
    m = '1;
    if (!sel) begin
      m[5] = 0; m[7] = 0; m[12] = 0; m[13] = 0; m[14] = 0; m[15] = 0;
    end else begin
      m[12] = 0; m[13] = 0; m[14] = 0; m[15] = 0; m[20] = 0; m[22] = 0;
    end
    return m;
  endfunction

  task automatic chk(input string tag, input logic [27:0] act, input logic [27:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [27:0] d, input logic cfg, input logic gate,
                      input logic [1:0] cs, input logic [1:0] odt, input logic [1:0] cke,
                      input logic bad, input string dtag, input string etag);
    logic cap;
    @(negedge clk);
    d_in = d; cfg_sel = cfg; gate_en = gate; cs_n_in = cs; odt_in = odt; cke_in = cke;
    par_in = (^m_q) ^ bad;
    cap   = !gate || (cs != 2'b11);
    m_err = m_cap ? !bad : 1'b1;
    if (cap) m_q = d & bench_mask(cfg);
    m_cap  = cap;
    m_ctrl = {cke, odt, cs};
    @(posedge clk);
    #1;
    chk(dtag, q_data, m_q);
    chk("R4", {22'd0, cke_q, odt_q, cs_n_q}, {22'd0, m_ctrl});
    chk(etag, {27'd0, err_n}, {27'd0, m_err});
  endtask

  task automatic release_reset_R10(input logic [27:0] d);
    @(negedge clk);
    d_in = d; cfg_sel = 1'b0; gate_en = 1'b0; cs_n_in = 2'b11;
    odt_in = 2'b11; cke_in = 2'b11; par_in = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R10 edge1 data", q_data, 28'd0);
    chk("R10 edge1 ctrl", {22'd0, cke_q, odt_q, cs_n_q}, 28'd0);
    @(posedge clk); #1;
    chk("R10 edge2 data", q_data, 28'd0);
    @(posedge clk); #1;
    chk("R10 edge3 data", q_data, d & bench_mask(1'b0));
    m_q = d & bench_mask(1'b0); m_cap = 1'b1; m_err = 1'b1; m_ctrl = 6'h3f;
    chk("R10 edge3 err", {27'd0, err_n}, 28'd1);
  endtask

  task automatic check_reset_R9;
    chk("R9 data", q_data, 28'd0);
    chk("R9 ctrl", {22'd0, cke_q, odt_q, cs_n_q}, 28'd0);
    chk("R9 err", {27'd0, err_n}, 28'd1);
  endtask

  task automatic test_ungated_R1;
    step(28'h5A5_A5A5, 1'b0, 1'b0, 2'b11, 2'b01, 2'b10, 1'b0, "R1", "R5");
    step(28'hFFF_0F0F, 1'b0, 1'b0, 2'b00, 2'b10, 2'b01, 1'b0, "R1", "R5");
    step(28'h123_4567, 1'b0, 1'b0, 2'b10, 2'b00, 2'b11, 1'b0, "R1", "R5");
  endtask

  task automatic test_selected_R2;
    step(28'hABC_DEF1, 1'b0, 1'b1, 2'b10, 2'b11, 2'b00, 1'b0, "R2", "R5");
    step(28'h0F0_F0F0, 1'b1, 1'b1, 2'b01, 2'b01, 2'b01, 1'b0, "R2", "R5");
    step(28'h7654_321, 1'b0, 1'b1, 2'b00, 2'b10, 2'b10, 1'b0, "R2", "R5");
  endtask

  task automatic test_hold_R3_R8;
    step(28'hFED_CBA9, 1'b0, 1'b1, 2'b11, 2'b00, 2'b11, 1'b0, "R3", "R5");
    step(28'h000_0001, 1'b1, 1'b1, 2'b11, 2'b11, 2'b00, 1'b1, "R3", "R8");
    step(28'hFFF_FFFF, 1'b0, 1'b1, 2'b11, 2'b01, 2'b10, 1'b1, "R3", "R8");
  endtask

  task automatic test_parity_R5_R6;
    step(28'h135_79BD, 1'b0, 1'b0, 2'b11, 2'b00, 2'b00, 1'b0, "R1", "R5");
    step(28'h246_8ACE, 1'b0, 1'b0, 2'b11, 2'b00, 2'b00, 1'b1, "R1", "R5 mismatch");
    step(28'h111_1111, 1'b1, 1'b0, 2'b11, 2'b00, 2'b00, 1'b0, "R1", "R6 pulse ends");
    step(28'h222_2222, 1'b1, 1'b0, 2'b11, 2'b00, 2'b00, 1'b1, "R1", "R6 second pulse");
    step(28'h333_3333, 1'b1, 1'b0, 2'b11, 2'b00, 2'b00, 1'b1, "R1", "R6 back to back");
    step(28'h333_3333, 1'b1, 1'b0, 2'b11, 2'b00, 2'b00, 1'b0, "R1", "R6");
  endtask

  task automatic test_cfg_R7;
    step(28'hFFF_FFFF, 1'b1, 1'b0, 2'b11, 2'b00, 2'b00, 1'b0, "R7 cfg1 ones", "R5");
    step(28'hFFF_FFFF, 1'b0, 1'b0, 2'b11, 2'b00, 2'b00, 1'b0, "R7 cfg0 ones", "R5");
    step(28'h000_0020, 1'b0, 1'b0, 2'b11, 2'b00, 2'b00, 1'b0, "R7 bit6 cfg0", "R5");
    step(28'h000_0020, 1'b1, 1'b0, 2'b11, 2'b00, 2'b00, 1'b0, "R7 bit6 cfg1", "R5");
    step(28'h050_0000, 1'b1, 1'b0, 2'b11, 2'b00, 2'b00, 1'b1, "R7 bits21,23 cfg1", "R5 inactive ignored");
    step(28'h050_0000, 1'b0, 1'b0, 2'b11, 2'b00, 2'b00, 1'b0, "R7 bits21,23 cfg0", "R6");
  endtask

  task automatic test_async_reset_R9;
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check_reset_R9();
    m_q = '0; m_cap = 1'b0; m_err = 1'b1; m_ctrl = '0;
    release_reset_R10(28'h9AB_CDEF);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cfg_sel = 1'b0; gate_en = 1'b0; d_in = '0; par_in = 1'b0;
    cs_n_in = 2'b11; odt_in = 2'b00; cke_in = 2'b00;
    m_q = '0; m_cap = 1'b0; m_err = 1'b1; m_ctrl = '0;
    repeat (3) @(posedge clk);
    #1 check_reset_R9();
    release_reset_R10(28'hC3C_3C3C);
    test_ungated_R1();
    test_selected_R2();
    test_hold_R3_R8();
    test_parity_R5_R6();
    test_cfg_R7();
    test_async_reset_R9();
    test_parity_R5_R6();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule